// File: doc/BRIEF.md
# Single-Step Bidirectional Word Shifter with Output Enable

This block moves an N-bit word by at most one bit position per use, with no clock and no storage. Two control lines decide the result: one selects whether a move happens at all, the other selects its direction. When a move happens, one bit leaves the word at one end and a new bit enters at the other. A two-bit fill selector decides what the new bit is: a constant zero, a constant one, or the bit that just left the opposite end, which makes the move a rotate.

Inside, a core stage works on an (N+2)-bit extended vector. This vector is the data word with one extra bit below bit 0 and one extra bit above bit N-1. A small edge-bit stage builds those two extra bits from the fill selector, so zero fill, one fill and rotate all use the same core. An output-enable line forces the whole result to zero. Several copies can then drive a shared OR-combined bus, and only the enabled copy contributes.

There are no states or transitions: the output is a pure function of the present inputs.

Top module: `step_shifter`

## Requirements
- R1: When `out_en` is 0, `word_out` is all zeros whatever the other inputs are.
- R2: When `out_en` is 1 and `move` is 0, `word_out` equals `word_in`, and `to_left` has no effect.
- R3: When `out_en`, `move` and `to_left` are all 1, `word_out[i]` equals `word_in[i-1]` for i from 1 to N-1.
- R4: When `out_en` and `move` are 1 and `to_left` is 0, `word_out[i]` equals `word_in[i+1]` for i from 0 to N-2.
- R5: With `fill_sel` = 2'b00 (zero fill), a left move puts 0 in `word_out[0]` and a right move puts 0 in `word_out[N-1]`.
- R6: With `fill_sel` = 2'b01 (one fill), a left move puts 1 in `word_out[0]` and a right move puts 1 in `word_out[N-1]`.
- R7: With `fill_sel` = 2'b10 (rotate), a left move puts `word_in[N-1]` in `word_out[0]` and a right move puts `word_in[0]` in `word_out[N-1]`.
- R8: `fill_sel` = 2'b11 behaves exactly like 2'b00.
- R9: The output follows any input change in the same time step; no clock edge is involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_in | input | N | Data word to be moved |
| move | input | 1 | 1 = move by one place, 0 = pass through |
| to_left | input | 1 | 1 = toward the MSB, 0 = toward the LSB |
| fill_sel | input | 2 | 00 zero fill, 01 one fill, 10 rotate, 11 zero fill |
| out_en | input | 1 | 0 forces the output to zero |
| word_out | output | N | Result word |

## Verification
The checker evaluates immediate assertions whenever the ports settle. It therefore assumes that every input is a known 0 or 1 and that `fill_sel` never carries X or Z. The bench drives every control combination from plain two-valued variables. It also changes inputs only between samples, so no check sees a half-updated input set. The end-bit assertions assume N of at least 2. The bench elaborates the default N of 8.

// File: rtl/step_shifter_pkg.sv
package step_shifter_pkg;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'b00,
        FILL_ONE  = 2'b01,
        FILL_ROT  = 2'b10,
        FILL_RSVD = 2'b11
    } fill_e;

endpackage

// File: rtl/edge_bits.sv
module edge_bits
    import step_shifter_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] word,
    input  fill_e        mode,
    output logic         lo_bit,
    output logic         hi_bit
);

    // lo_bit enters at position 0 on a left move; hi_bit enters at N-1 on a right move
    always_comb begin
        unique case (mode)
            FILL_ONE: begin
                lo_bit = 1'b1;
                hi_bit = 1'b1;
            end
            FILL_ROT: begin
                lo_bit = word[N-1];
                hi_bit = word[0];
            end
            FILL_ZERO, FILL_RSVD: begin
                lo_bit = 1'b0;
                hi_bit = 1'b0;
            end
            default: begin
                lo_bit = 1'b0;
                hi_bit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/shift_core.sv
module shift_core #(
    parameter int N  = 8,
    localparam int XW = N + 2
) (
    input  logic [XW-1:0] x_ext,   // x_ext[k] holds logical bit k-1
    input  logic          move,
    input  logic          to_left,
    output logic [N-1:0]  y
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            if (!move)
                y[i] = x_ext[i + 1];
            else if (to_left)
                y[i] = x_ext[i];
            else
                y[i] = x_ext[i + 2];
        end
    end

endmodule

// File: rtl/out_gate.sv
module out_gate #(
    parameter int N = 8
) (
    input  logic [N-1:0] d,
    input  logic         en,
    output logic [N-1:0] q
);

    assign q = d & {N{en}};

endmodule

// File: rtl/step_shifter.sv
module step_shifter
    import step_shifter_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] word_in,
    input  logic         move,
    input  logic         to_left,
    input  logic [1:0]   fill_sel,
    input  logic         out_en,
    output logic [N-1:0] word_out
);

    localparam int XW = N + 2;

    fill_e           mode;
    logic            lo_bit;
    logic            hi_bit;
    logic [XW-1:0]   x_ext;
    logic [N-1:0]    moved;

    assign mode  = fill_e'(fill_sel);
    assign x_ext = {hi_bit, word_in, lo_bit};

    edge_bits #(.N(N)) u_edge (
        .word   (word_in),
        .mode   (mode),
        .lo_bit (lo_bit),
        .hi_bit (hi_bit)
    );

    shift_core #(.N(N)) u_core (
        .x_ext   (x_ext),
        .move    (move),
        .to_left (to_left),
        .y       (moved)
    );

    out_gate #(.N(N)) u_gate (
        .d  (moved),
        .en (out_en),
        .q  (word_out)
    );

endmodule

// File: rtl/step_shifter_chk.sv
module step_shifter_chk #(
    parameter int N = 8
) (
    input logic [N-1:0] word_in,
    input logic         move,
    input logic         to_left,
    input logic [1:0]   fill_sel,
    input logic         out_en,
    input logic [N-1:0] word_out
);

    always_comb begin
        // R1
        gated_zero_chk: assert (out_en || word_out == '0);
        // R2
        pass_through_chk: assert (!(out_en && !move) || word_out == word_in);
        // R3
        left_body_chk: assert (!(out_en && move && to_left) || word_out[N-1:1] == word_in[N-2:0]);
        // R4
        right_body_chk: assert (!(out_en && move && !to_left) || word_out[N-2:0] == word_in[N-1:1]);
        // R5 R8
        zero_fill_chk: assert (!(out_en && move && fill_sel != 2'b01 && fill_sel != 2'b10)
                               || (to_left ? !word_out[0] : !word_out[N-1]));
        // R6
        one_fill_chk: assert (!(out_en && move && fill_sel == 2'b01)
                              || (to_left ? word_out[0] : word_out[N-1]));
        // R7
        rotate_chk: assert (!(out_en && move && fill_sel == 2'b10)
                            || (to_left ? word_out[0] == word_in[N-1] : word_out[N-1] == word_in[0]));
    end

endmodule

bind step_shifter step_shifter_chk #(.N(N)) u_chk (
    .word_in  (word_in),
    .move     (move),
    .to_left  (to_left),
    .fill_sel (fill_sel),
    .out_en   (out_en),
    .word_out (word_out)
);

// File: tb/tb_step_shifter.sv
module tb_step_shifter;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic [N-1:0] word_in = '0;
    logic         move = 1'b0;
    logic         to_left = 1'b0;
    logic [1:0]   fill_sel = 2'b00;
    logic         out_en = 1'b0;
    logic [N-1:0] word_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    step_shifter #(.N(N)) dut (
        .word_in  (word_in),
        .move     (move),
        .to_left  (to_left),
        .fill_sel (fill_sel),
        .out_en   (out_en),
        .word_out (word_out)
    );

    // {req[3:0], en, move, left, fill[1:0], data[7:0], expect[7:0]}
    localparam int NV = 13;
    localparam logic [24:0] VEC [NV] = '{
        {4'd1, 1'b0, 1'b1, 1'b1, 2'b00, 8'hA5, 8'h00},  // R1
        {4'd2, 1'b1, 1'b0, 1'b1, 2'b01, 8'hA5, 8'hA5},  // R2
        {4'd5, 1'b1, 1'b1, 1'b1, 2'b00, 8'hA5, 8'h4A},  // R5 R3
        {4'd6, 1'b1, 1'b1, 1'b1, 2'b01, 8'hA5, 8'h4B},  // R6
        {4'd7, 1'b1, 1'b1, 1'b1, 2'b10, 8'hA5, 8'h4B},  // R7
        {4'd4, 1'b1, 1'b1, 1'b0, 2'b00, 8'hA5, 8'h52},  // R4 R5
        {4'd6, 1'b1, 1'b1, 1'b0, 2'b01, 8'hA5, 8'hD2},  // R6
        {4'd7, 1'b1, 1'b1, 1'b0, 2'b10, 8'hA5, 8'hD2},  // R7
        {4'd7, 1'b1, 1'b1, 1'b0, 2'b10, 8'h4A, 8'h25},  // R7
        {4'd7, 1'b1, 1'b1, 1'b1, 2'b10, 8'h4A, 8'h94},  // R7
        {4'd8, 1'b1, 1'b1, 1'b1, 2'b11, 8'hFF, 8'hFE},  // R8
        {4'd8, 1'b1, 1'b1, 1'b0, 2'b11, 8'hFF, 8'h7F},  // R8
        {4'd2, 1'b1, 1'b0, 1'b0, 2'b11, 8'h3C, 8'h3C}   // R2
    };

    function automatic logic [N-1:0] ref_model(input logic [N-1:0] w, input logic en,
                                               input logic mv, input logic lf,
                                               input logic [1:0] fs);
        logic ins_lo, ins_hi;
        if (!en) return '0;
        if (!mv) return w;
        ins_lo = (fs == 2'b01) ? 1'b1 : (fs == 2'b10) ? w[N-1] : 1'b0;
        ins_hi = (fs == 2'b01) ? 1'b1 : (fs == 2'b10) ? w[0]   : 1'b0;
        return lf ? {w[N-2:0], ins_lo} : {ins_hi, w[N-1:1]};
    endfunction

    task automatic check(input int req, input logic [N-1:0] exp_v);
        checks++;
        if (word_out !== exp_v) begin
            errors++;
            $display("FAIL R%0d: word_out=%h expected=%h (en=%b move=%b left=%b fill=%b in=%h)",
                     req, word_out, exp_v, out_en, move, to_left, fill_sel, word_in);
        end
    endtask

    task automatic apply(input logic e, input logic m, input logic l,
                         input logic [1:0] f, input logic [N-1:0] w);
        @(negedge clk);
        out_en = e; move = m; to_left = l; fill_sel = f; word_in = w;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        // R1: initial state with enable low gives zero output
        #1;
        check(1, '0);

        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][20], VEC[v][19], VEC[v][18], VEC[v][17:16], VEC[v][15:8]);
            check(int'(VEC[v][24:21]), VEC[v][7:0]);
        end

        // all control combinations against the reference model, random data
        for (int c = 0; c < 32; c++) begin
            for (int k = 0; k < 12; k++) begin
                logic [N-1:0] w;
                w = N'($urandom);
                apply(c[4], c[3], c[2], c[1:0], w);
                check(!c[4] ? 1 : !c[3] ? 2 : c[2] ? 3 : 4,
                      ref_model(w, c[4], c[3], c[2], c[1:0]));
            end
        end

        // R2: direction input has no effect in pass-through
        apply(1, 0, 0, 2'b10, 8'h81);
        check(2, 8'h81);
        to_left = 1; #1;
        check(2, 8'h81);

        // R1: enable low with all-ones data and one fill
        apply(0, 1, 0, 2'b01, 8'hFF);
        check(1, 8'h00);

        // R9: output follows input with no clock edge in between
        apply(1, 1, 1, 2'b10, 8'h80);
        check(7, 8'h01);
        word_in = 8'h01; #1;
        check(9, 8'h02);
        to_left = 0; #1;
        check(9, 8'h80);
        out_en = 0; #1;
        check(9, 8'h00);

        // R8: reserved code with rotate-sensitive data
        apply(1, 1, 0, 2'b11, 8'h01);
        check(8, 8'h00);
        apply(1, 1, 1, 2'b11, 8'h80);
        check(8, 8'h00);

        finish_run();
    end

endmodule